// File: doc/BRIEF.md
# Dual Compare Timer

This block keeps a free-running tick counter and watches it with two independent compare channels, one owned by the supervisor and one owned by the hypervisor. Each channel holds a compare word whose low bits are a target count and whose top bit turns the channel's interrupt effect off. When an increment of the counter lands exactly on a channel's target, that channel emits a one-cycle match pulse.

The supervisor channel turns an enabled match into a one-cycle strobe that the surrounding logic uses to set the timer bit (bit 16) of its soft interrupt register. The hypervisor channel turns an enabled match into a sticky pending flag, and that flag drives the hypervisor interrupt line until software writes the flag back to zero. Software reaches both compare words and the pending flag through a single-cycle write port. The counter advances once for every cycle in which the tick enable is high.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the count is zero, both compare words hold target zero with the disable bit set, the pending flag is clear, and all outputs are low.
- R2: The count advances by exactly one on each clock edge with `tickEn` high, holds on every other edge, and wraps from all ones to zero.
- R3: A channel's match output is high for exactly the one cycle after an edge at which `tickEn` was high and the incremented count equals bits CNT_W-1:0 of that channel's compare word; it is low at all other times.
- R4: A write with `wrAddr` 0 loads the supervisor compare word, 1 loads the hypervisor compare word, 2 loads the pending flag from `wrData` bit 0, and 3 changes nothing. A compare word written on an edge is the one compared at that same edge, so a target equal to the next count fires on that edge.
- R5: Rewriting a compare word discards the old target: no match fires when the count passes the old target.
- R6: A target equal to or behind the current count fires only after the counter wraps around and reaches it, exactly 2^CNT_W increments after a target equal to the count was written.
- R7: Bit CNT_W of the supervisor compare word is its disable bit; `softTimerSet` pulses together with `supMatch` when that bit is clear and stays low when it is set.
- R8: A hypervisor match with its disable bit (bit CNT_W) clear sets the pending flag; `hypIrq` equals the flag and stays high until software clears it. A disabled hypervisor match leaves the flag unchanged.
- R9: A write to the pending flag sets or clears it; when an enabled hypervisor match and a clearing write happen on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Advance the counter on this edge |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write target: 0 supervisor compare, 1 hypervisor compare, 2 pending flag, 3 none |
| wrData | input | CNT_W+1 | Write data; top bit is the disable bit for compare words |
| tickCount | output | CNT_W | Current counter value |
| supMatch | output | 1 | Supervisor match pulse |
| softTimerSet | output | 1 | Strobe to set the soft interrupt timer bit |
| hypMatch | output | 1 | Hypervisor match pulse |
| hypIrq | output | 1 | Hypervisor interrupt line (pending flag) |

## Verification
A corrupted counter shows at `tickCount` on the very next edge, and a stale or mis-loaded compare word shows as a match pulse one cycle late, early, missing, or repeated at the wrong count, which a cycle-exact reference model of the bench catches on the edge it happens. A pending flag in the wrong state shows directly on `hypIrq` one cycle after the offending match or write. Directed scenarios place targets at the next count, behind the count, across a wrap and under a rewrite, so each ordering rule is observed at the exact edge it governs.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    ADDR_SUP  = 2'd0,
    ADDR_HYP  = 2'd1,
    ADDR_PEND = 2'd2,
    ADDR_NONE = 2'd3
  } wrAddr_e;

  // Load strobes from control to datapath
  typedef struct packed {
    logic ldSup;
    logic ldHyp;
  } cmpLoad_t;
endpackage

// File: rtl/dct_datapath.sv
module dct_datapath
  import dct_pkg::*;
#(
  parameter int CNT_W = 63,
  localparam int CMP_W = CNT_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  cmpLoad_t            ld,
  input  logic [CMP_W-1:0]    wrData,
  output logic [CNT_W-1:0]    count,
  output logic [NUM_CH-1:0]   hit,
  output logic [NUM_CH-1:0]   hitDis
);
  logic [CNT_W-1:0] nextCount;
  logic [NUM_CH-1:0] loadCh;

  assign nextCount = count + 1'b1;
  assign loadCh[0] = ld.ldSup;
  assign loadCh[1] = ld.ldHyp;

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else if (tickEn) count <= nextCount;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gCh
    logic [CMP_W-1:0] cmpQ;
    logic [CMP_W-1:0] effCmp;

    // A word written on this edge is the one compared on this edge
    assign effCmp = loadCh[ch] ? wrData : cmpQ;

    always_ff @(posedge clk) begin
      if (!rstN) cmpQ <= {1'b1, {CNT_W{1'b0}}};
      else if (loadCh[ch]) cmpQ <= wrData;
    end

    assign hit[ch]    = tickEn && (nextCount == effCmp[CNT_W-1:0]);
    assign hitDis[ch] = effCmp[CNT_W];
  end
endmodule

// File: rtl/dct_control.sv
module dct_control
  import dct_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic              wrBit0,
  input  logic [NUM_CH-1:0] hit,
  input  logic [NUM_CH-1:0] hitDis,
  output cmpLoad_t          ld,
  output logic              supMatch,
  output logic              softTimerSet,
  output logic              hypMatch,
  output logic              hypIrq
);
  wrAddr_e addrSel;
  logic pendWr;
  logic pendSet;

  assign addrSel  = wrAddr_e'(wrAddr);
  assign ld.ldSup = wrEn && (addrSel == ADDR_SUP);
  assign ld.ldHyp = wrEn && (addrSel == ADDR_HYP);
  assign pendWr   = wrEn && (addrSel == ADDR_PEND);
  assign pendSet  = hit[1] && !hitDis[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      supMatch     <= 1'b0;
      softTimerSet <= 1'b0;
      hypMatch     <= 1'b0;
      hypIrq       <= 1'b0;
    end else begin
      supMatch     <= hit[0];
      softTimerSet <= hit[0] && !hitDis[0];
      hypMatch     <= hit[1];
      // An enabled match wins over a simultaneous software write
      if (pendSet) hypIrq <= 1'b1;
      else if (pendWr) hypIrq <= wrBit0;
    end
  end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dct_pkg::*;
#(
  parameter int CNT_W = 63,
  localparam int CMP_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CMP_W-1:0] wrData,
  output logic [CNT_W-1:0] tickCount,
  output logic             supMatch,
  output logic             softTimerSet,
  output logic             hypMatch,
  output logic             hypIrq
);
  cmpLoad_t ld;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] hitDis;

  dct_control uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrBit0(wrData[0]),
    .hit(hit), .hitDis(hitDis), .ld(ld), .supMatch(supMatch),
    .softTimerSet(softTimerSet), .hypMatch(hypMatch), .hypIrq(hypIrq)
  );

  dct_datapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .ld(ld), .wrData(wrData),
    .count(tickCount), .hit(hit), .hitDis(hitDis)
  );
endmodule

// File: rtl/dual_cmp_timer_chk.sv
module dual_cmp_timer_chk #(
  parameter int CNT_W = 63,
  localparam int CMP_W = CNT_W + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             wrEn,
  input logic [1:0]       wrAddr,
  input logic [CMP_W-1:0] wrData,
  input logic [CNT_W-1:0] tickCount,
  input logic             supMatch,
  input logic             softTimerSet,
  input logic             hypMatch,
  input logic             hypIrq
);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> tickCount == $past(tickCount) + 1'b1);
  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(tickCount));
  // R3
  sup_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(supMatch) |-> $past(tickEn));
  // R3
  hyp_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hypMatch) |-> $past(tickEn));
  // R7
  soft_needs_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    softTimerSet |-> supMatch);
  // R8
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hypIrq) |-> (hypMatch || $past(wrEn && wrAddr == 2'd2 && wrData[0])));
  // R9
  irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hypIrq) |-> $past(wrEn && wrAddr == 2'd2 && !wrData[0]));
endmodule

bind dual_cmp_timer dual_cmp_timer_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .tickCount(tickCount), .supMatch(supMatch),
  .softTimerSet(softTimerSet), .hypMatch(hypMatch), .hypIrq(hypIrq)
);

// File: tb/sim_dual_cmp_timer.sv
`timescale 1ns/1ps
module sim_dual_cmp_timer;
  localparam int W = 10;
  localparam int CW = W + 1;
  localparam logic [CW-1:0] DIS = CW'(1) << W;

  logic clk = 0, rstN = 0, tickEn = 0, wrEn = 0;
  logic [1:0] wrAddr = 0;
  logic [CW-1:0] wrData = 0;
  logic [W-1:0] tickCount;
  logic supMatch, softTimerSet, hypMatch, hypIrq;

  int total = 0, fails = 0;
  bit done = 0;

  // Reference model
  logic [W-1:0] mCnt = 0;
  logic [CW-1:0] mSup = DIS, mHyp = DIS;
  logic mPend = 0, eSup = 0, eSoft = 0, eHyp = 0;

  always #4 clk = ~clk;

  dual_cmp_timer #(.CNT_W(W)) u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .tickCount(tickCount), .supMatch(supMatch),
    .softTimerSet(softTimerSet), .hypMatch(hypMatch), .hypIrq(hypIrq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock: drive, model, advance, compare
  task automatic step(input bit t, input bit we, input logic [1:0] a, input logic [CW-1:0] d);
    logic [CW-1:0] effS, effH;
    logic [W-1:0] nc;
    logic hs, hh;
    tickEn = t; wrEn = we; wrAddr = a; wrData = d;
    effS = (we && a == 2'd0) ? d : mSup;
    effH = (we && a == 2'd1) ? d : mHyp;
    nc = mCnt + 1'b1;
    hs = t && (nc == effS[W-1:0]);
    hh = t && (nc == effH[W-1:0]);
    if (hh && !effH[W]) mPend = 1'b1;
    else if (we && a == 2'd2) mPend = d[0];
    mSup = effS; mHyp = effH;
    if (t) mCnt = nc;
    eSup = hs; eSoft = hs && !effS[W]; eHyp = hh;
    @(posedge clk);
    @(negedge clk);
    tickEn = 0; wrEn = 0; wrAddr = 0; wrData = 0;
    check("R2 count", tickCount, mCnt);
    check("R3 supMatch", supMatch, eSup);
    check("R7 softTimerSet", softTimerSet, eSoft);
    check("R3 hypMatch", hypMatch, eHyp);
    check("R8 hypIrq", hypIrq, mPend);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0);
  endtask

  task automatic t_reset();
    check("R1 count", tickCount, 0);
    check("R1 outputs", {supMatch, softTimerSet, hypMatch, hypIrq}, 0);
    tick(3); // R1: disabled compare of zero is far away, nothing fires
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    check("R2 hold", tickCount, 3);
  endtask

  task automatic t_supMatch();
    step(0, 1, 2'd0, CW'(mCnt + 4));
    tick(3);
    check("R3 no early match", supMatch, 0);
    tick(1);
    check("R3 sup fires", supMatch, 1);
    check("R7 soft set enabled", softTimerSet, 1);
    tick(1);
    check("R3 single pulse", supMatch, 0);
    step(0, 1, 2'd0, DIS | CW'(mCnt + 2));
    tick(2);
    check("R7 disabled still matches", supMatch, 1);
    check("R7 disabled no soft", softTimerSet, 0);
  endtask

  task automatic t_hypPend();
    step(0, 1, 2'd1, CW'(mCnt + 2));
    tick(2);
    check("R8 hyp fires", hypMatch, 1);
    check("R8 irq set", hypIrq, 1);
    tick(5);
    check("R8 irq sticky", hypIrq, 1);
    step(0, 1, 2'd2, 0);
    check("R9 cleared", hypIrq, 0);
    step(0, 1, 2'd1, DIS | CW'(mCnt + 1));
    tick(1);
    check("R8 disabled match", hypMatch, 1);
    check("R8 disabled no irq", hypIrq, 0);
    step(0, 1, 2'd2, 1);
    check("R9 set by write", hypIrq, 1);
    step(0, 1, 2'd2, 0);
    step(0, 1, 2'd3, CW'(mCnt + 1)); // R4 address 3 ignored
    tick(1);
    check("R4 addr3 no effect", {supMatch, hypMatch, hypIrq}, 0);
  endtask

  task automatic t_sameEdge();
    step(1, 1, 2'd0, CW'(mCnt + 1));
    check("R4 next-count write fires", supMatch, 1);
    step(0, 1, 2'd1, CW'(mCnt + 1));
    step(1, 1, 2'd2, 0); // R9 match beats clear
    check("R9 match wins", hypIrq, 1);
    step(0, 1, 2'd2, 0);
  endtask

  task automatic t_rewrite();
    step(0, 1, 2'd0, CW'(mCnt + 3));
    step(0, 1, 2'd0, CW'(mCnt + 8));
    tick(3);
    check("R5 old target dropped", supMatch, 0);
    tick(5);
    check("R5 new target fires", supMatch, 1);
  endtask

  task automatic t_wrap();
    int hits = 0;
    step(0, 1, 2'd0, CW'(mCnt)); // R6 target equals current count
    for (int i = 1; i <= (1 << W); i++) begin
      step(1, 0, 0, 0);
      if (supMatch) begin
        hits++;
        check("R6 fires only after full wrap", i, 1 << W);
      end
    end
    check("R6 exactly one match", hits, 1);
    while (mCnt != '1) step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    check("R2 wrap to zero", tickCount, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    t_reset();
    t_supMatch();
    t_hypPend();
    t_sameEdge();
    t_rewrite();
    t_wrap();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule